// File: doc/BRIEF.md
# Word-Wide Fuse Reader with Byte Trimming

This block reads bytes out of a one-time-programmable fuse array of 32 words by 32 bits. The array returns one full 32-bit word for each strobe. A host asks for any byte offset and byte count. The block finds the aligned words that cover the range and reads each of them with a timed control-word sequence. It then streams out exactly the requested bytes, in address order, on a valid/ready byte port. Bytes in front of the offset and bytes past the end of the range are dropped.

When a read ends, or when a request is refused, the control word returns to a power-down standby value. The host sees a one-cycle completion pulse, together with an error flag when a request was refused. The three timing windows are parameters counted in clock cycles: read-mode settle, strobe width and strobe-low hold.

Top module: `fuse_word_reader`

## Requirements
- R1: Out of reset, and whenever the block is idle, `fuse_ctrl_o` equals 0x0000_0021 (power-down at bit 5 and chip-select-bar at bit 0, all other bits low), `req_ready_o` is high and `byte_valid_o` is low.
- R2: Once a non-empty, in-range request is accepted, `fuse_ctrl_o` equals 0x0000_028C for exactly SETUP_CYC cycles before the first strobe. This value sets read-select-bar (bit 7), strobe-soft-select (bit 9), program-enable-bar (bit 3) and load (bit 2).
- R3: Each word read drives strobe (bit 1) and the word index (10-bit field at bit 16) in the same cycle: `fuse_ctrl_o` = 0x0000_028E | (index << 16) for exactly STROBE_CYC cycles. `fuse_dout_i` is captured in the last of those cycles.
- R4: After each strobe, `fuse_ctrl_o` drops bit 1 and keeps the index. It stays there for exactly HOLD_CYC cycles before the first byte of that word is offered.
- R5: The words strobed are floor(offset/4) up to ceil((offset+count)/4)-1, each once, in ascending order.
- R6: Exactly `count` bytes are delivered. The first byte is lane offset mod 4 of the first word, and lanes run least significant first (lane n is bits 8n+7:8n). Byte k of the stream is fuse byte offset+k.
- R7: While `byte_valid_o` is high and `byte_ready_i` is low, the byte stays valid and unchanged. No strobe is issued while a byte is pending.
- R8: After the last byte is accepted, `done_o` pulses high for one cycle. In that cycle `fuse_ctrl_o` is back at standby 0x0000_0021 and `err_o` is low.
- R9: A request with count 0 gets `done_o` with `err_o` low. No strobe is issued and no byte is sent.
- R10: A request with count > 0 and offset+count > 128 gets `done_o` with `err_o` high. No strobe is issued and no byte is sent. `err_o` is never high without `done_o`.
- R11: `req_ready_o` is low from acceptance until the completion pulse, so no request is taken while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken on this edge |
| req_offset_i | input | POS_W (8) | Starting byte offset |
| req_count_i | input | POS_W (8) | Number of bytes wanted |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request refused, valid with done_o |
| byte_valid_o | output | 1 | Output byte present |
| byte_data_o | output | 8 | Output byte |
| byte_ready_i | input | 1 | Sink takes the byte |
| fuse_ctrl_o | output | 32 | Control word to the fuse macro |
| fuse_dout_i | input | 32 | Word read back from the fuse macro |

## Verification
The assertions assume that `byte_ready_i` and the request inputs change only between clock edges and are free of X after reset. They assume nothing about the contents of `fuse_dout_i`, because the block only captures it. The bench models the macro as a combinational word lookup that is live only while strobe is high. It drives every input one time unit after a rising edge, with ready held high or pulsed once every three cycles. It also keeps each request valid only until its acceptance edge, so the stall and no-strobe-while-pending properties are exercised under both sink patterns.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  localparam int CTRL_W   = 32;
  localparam int B_CSB    = 0;
  localparam int B_STB    = 1;
  localparam int B_LOAD   = 2;
  localparam int B_PGENB  = 3;
  localparam int B_PD     = 5;
  localparam int B_RSB    = 7;
  localparam int B_SSS    = 9;
  localparam int ADDR_LSB = 16;
  localparam int ADDR_W   = 10;

  localparam logic [CTRL_W-1:0] CTRL_STANDBY =
    (CTRL_W'(1) << B_PD) | (CTRL_W'(1) << B_CSB);
  localparam logic [CTRL_W-1:0] CTRL_READ =
    (CTRL_W'(1) << B_LOAD) | (CTRL_W'(1) << B_PGENB) |
    (CTRL_W'(1) << B_SSS)  | (CTRL_W'(1) << B_RSB);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_SEND, ST_DONE
  } fwr_state_e;
endpackage

// File: rtl/fwr_range.sv
module fwr_range #(
  parameter int BYTES = 128,
  parameter int POS_W = 8
) (
  input  logic [POS_W-1:0] off_i,
  input  logic [POS_W-1:0] cnt_i,
  output logic [POS_W:0]   end_o,
  output logic             zero_o,
  output logic             err_o
);
  assign end_o  = {1'b0, off_i} + {1'b0, cnt_i};
  assign zero_o = (cnt_i == '0);
  assign err_o  = !zero_o && (end_o > (POS_W+1)'(BYTES));
endmodule

// File: rtl/fwr_timer.sv
module fwr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fwr_lane_mux.sv
module fwr_lane_mux #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic [LANES*8-1:0] word_i,
  input  logic [LANE_W-1:0]  lane_i,
  output logic [7:0]         byte_o
);
  logic [7:0] lane_b [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_b[g] = word_i[g*8 +: 8];
  end

  assign byte_o = lane_b[lane_i];
endmodule

// File: rtl/fuse_word_reader.sv
module fuse_word_reader
  import fwr_pkg::*;
#(
  parameter int WORDS      = 32,
  parameter int SETUP_CYC  = 100,
  parameter int STROBE_CYC = 100,
  parameter int HOLD_CYC   = 100,
  localparam int POS_W     = $clog2(WORDS*4) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [POS_W-1:0]  req_offset_i,
  input  logic [POS_W-1:0]  req_count_i,
  output logic              done_o,
  output logic              err_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  input  logic              byte_ready_i,
  output logic [31:0]       fuse_ctrl_o,
  input  logic [31:0]       fuse_dout_i
);
  localparam int LANES   = 4;
  localparam int LANE_W  = 2;
  localparam int BYTES   = WORDS * LANES;
  localparam int WIDX_W  = $clog2(WORDS);
  localparam int MAX_CYC = (SETUP_CYC > STROBE_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] SETUP_LEN  = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] STROBE_LEN = TMR_W'(STROBE_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_LEN   = TMR_W'(HOLD_CYC - 1);

  fwr_state_e         state_q, state_d;
  logic [POS_W:0]     pos_q, end_q, pos_inc, rng_end;
  logic [WIDX_W-1:0]  word_q;
  logic [31:0]        data_q;
  logic               err_q, rng_zero, rng_err;
  logic               tmr_load, tmr_expired;
  logic [TMR_W-1:0]   tmr_len;

  fwr_range #(.BYTES(BYTES), .POS_W(POS_W)) u_range (
    .off_i  (req_offset_i),
    .cnt_i  (req_count_i),
    .end_o  (rng_end),
    .zero_o (rng_zero),
    .err_o  (rng_err)
  );

  fwr_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .len_i     (tmr_len),
    .expired_o (tmr_expired)
  );

  fwr_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
    .word_i (data_q),
    .lane_i (pos_q[LANE_W-1:0]),
    .byte_o (byte_data_o)
  );

  assign pos_inc = pos_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (rng_zero || rng_err) begin
          state_d = ST_DONE;
        end else begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_len  = SETUP_LEN;
        end
      end
      ST_SETUP: if (tmr_expired) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_len  = STROBE_LEN;
      end
      ST_STROBE: if (tmr_expired) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_len  = HOLD_LEN;
      end
      ST_HOLD: if (tmr_expired) state_d = ST_SEND;
      ST_SEND: if (byte_ready_i) begin
        if (pos_inc == end_q) begin
          state_d = ST_DONE;
        end else if (pos_inc[LANE_W-1:0] == '0) begin
          // word boundary: next strobe only after this byte left
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_len  = STROBE_LEN;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      end_q   <= '0;
      word_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        pos_q <= {1'b0, req_offset_i};
        end_q <= rng_end;
        err_q <= rng_err;
      end
      if (state_q == ST_SETUP) word_q <= pos_q[WIDX_W+LANE_W-1:LANE_W];
      if (state_q == ST_STROBE && tmr_expired) data_q <= fuse_dout_i;
      if (state_q == ST_SEND && byte_ready_i) begin
        pos_q <= pos_inc;
        if (pos_inc[LANE_W-1:0] == '0) word_q <= pos_inc[WIDX_W+LANE_W-1:LANE_W];
      end
    end
  end

  always_comb begin
    fuse_ctrl_o = CTRL_STANDBY;
    unique case (state_q)
      ST_SETUP:          fuse_ctrl_o = CTRL_READ;
      ST_STROBE: begin
        fuse_ctrl_o = CTRL_READ | (CTRL_W'(1) << B_STB);
        fuse_ctrl_o[ADDR_LSB +: ADDR_W] = ADDR_W'(word_q);
      end
      ST_HOLD, ST_SEND: begin
        fuse_ctrl_o = CTRL_READ;
        fuse_ctrl_o[ADDR_LSB +: ADDR_W] = ADDR_W'(word_q);
      end
      default:           fuse_ctrl_o = CTRL_STANDBY;
    endcase
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign byte_valid_o = (state_q == ST_SEND);
  assign done_o       = (state_q == ST_DONE);
  assign err_o        = done_o && err_q;
endmodule

// File: rtl/fwr_checker.sv
module fwr_checker
  import fwr_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        err_o,
  input logic        byte_valid_o,
  input logic [7:0]  byte_data_o,
  input logic        byte_ready_i,
  input logic [31:0] fuse_ctrl_o
);
  logic stb;
  assign stb = fuse_ctrl_o[B_STB];

  a_r1_idle_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (fuse_ctrl_o == CTRL_STANDBY) && !byte_valid_o);

  a_r3_strobe_read_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb |-> fuse_ctrl_o[B_LOAD] && fuse_ctrl_o[B_PGENB] && fuse_ctrl_o[B_RSB] &&
            fuse_ctrl_o[B_SSS] && !fuse_ctrl_o[B_PD] && !fuse_ctrl_o[B_CSB]);

  a_r3_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && $past(stb) |-> $stable(fuse_ctrl_o[ADDR_LSB +: ADDR_W]));

  a_r7_hold_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_data_o));

  a_r7_no_strobe_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> !stb);

  a_r8_done_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fuse_ctrl_o == CTRL_STANDBY) && !byte_valid_o);

  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r11_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o || stb || done_o) |-> !req_ready_o);
endmodule

bind fuse_word_reader fwr_checker u_chk (.*);

// File: tb/fuse_word_reader_test.sv
module fuse_word_reader_test;
  localparam int SETUP  = 3;
  localparam int STROBE = 4;
  localparam int HOLD   = 2;
  localparam int NV     = 9;
  localparam logic [7:0] V_OFF  [NV] = '{8'd0, 8'd1, 8'd3, 8'd5, 8'd0, 8'd124, 8'd126, 8'd10, 8'd2};
  localparam logic [7:0] V_CNT  [NV] = '{8'd4, 8'd2, 8'd2, 8'd9, 8'd128, 8'd4, 8'd2, 8'd1, 8'd7};
  localparam bit         V_STALL[NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, done, err, bvalid, bready = 1'b1;
  logic [7:0] req_off = '0, req_cnt = '0, bdata;
  logic [31:0] ctrl, dout;

  int total = 0, bad = 0, cycles = 0;
  bit stall_mode = 1'b0, active = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] fb(int p);
    return 8'((p * 37 + 11) & 255);
  endfunction
  function automatic logic [31:0] fword(int a);
    return {fb(4*a+3), fb(4*a+2), fb(4*a+1), fb(4*a)};
  endfunction

  assign dout = ctrl[1] ? fword(int'(ctrl[25:16])) : 32'h0;

  fuse_word_reader #(.WORDS(32), .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_offset_i(req_off), .req_count_i(req_cnt), .done_o(done), .err_o(err),
    .byte_valid_o(bvalid), .byte_data_o(bdata), .byte_ready_i(bready),
    .fuse_ctrl_o(ctrl), .fuse_dout_i(dout));

  // monitor logs
  logic [7:0] blog [256];
  int wlog [64];
  int bn, wn, setup_cnt, run, gap, bad_run, bad_gap, bad_ctrl, bad_overlap, bad_stab, busy_ready;
  bit prev_s, in_gap, stalled, done_seen, done_err;
  logic [7:0] stalled_data;
  logic [31:0] ctrl_at_done;

  task automatic clear_log();
    bn = 0; wn = 0; setup_cnt = 0; run = 0; gap = 0; bad_run = 0; bad_gap = 0;
    bad_ctrl = 0; bad_overlap = 0; bad_stab = 0; busy_ready = 0;
    prev_s = 0; in_gap = 0; stalled = 0; done_seen = 0; done_err = 0; ctrl_at_done = '0;
  endtask

  always @(negedge clk) begin
    if (active && !done_seen) begin
      if (ctrl == 32'h0000_028C && wn == 0) setup_cnt++;
      if (ctrl[1]) begin
        if (!prev_s) begin
          if (wn < 64) wlog[wn] = int'(ctrl[25:16]);
          wn++;
          run = 1;
        end else run++;
        if (ctrl != (32'h0000_028E | {6'd0, ctrl[25:16], 16'd0})) bad_ctrl++;
        if (bvalid) bad_overlap++;
      end
      if (!ctrl[1] && prev_s) begin
        if (run != STROBE) bad_run++;
        in_gap = 1; gap = 0;
      end
      if (in_gap) begin
        if (bvalid) begin
          if (gap != HOLD) bad_gap++;
          in_gap = 0;
        end else gap++;
      end
      if (stalled && (!bvalid || bdata != stalled_data)) bad_stab++;
      stalled = bvalid && !bready;
      stalled_data = bdata;
      if (bvalid && bready) begin
        if (bn < 256) blog[bn] = bdata;
        bn++;
      end
      if (req_ready && !req_valid) busy_ready++;
      if (done) begin
        done_seen = 1; done_err = err; ctrl_at_done = ctrl;
      end
      prev_s = ctrl[1];
    end
  end

  initial begin : ready_drv
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      ph = (ph + 1) % 3;
      bready = stall_mode ? (ph == 0) : 1'b1;
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(int off, int cnt, bit stall);
    int wait_cyc = 0;
    clear_log();
    stall_mode = stall;
    @(posedge clk); #1;
    req_off = 8'(off); req_cnt = 8'(cnt); req_valid = 1'b1; active = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!done_seen && wait_cyc < 20000) begin
      @(posedge clk); #1;
      wait_cyc++;
    end
    @(negedge clk);
    active = 1'b0;
    chk(done_seen, "R8", "done pulse seen", done_seen, 1);
  endtask

  task automatic check_read(int off, int cnt);
    int w0 = off / 4;
    int w1 = (off + cnt + 3) / 4;
    int mism = -1;
    chk(!done_err, "R8", "err on good read", done_err, 0);
    chk(ctrl_at_done == 32'h21, "R8", "standby at done", ctrl_at_done, 32'h21);
    chk(setup_cnt == SETUP, "R2", "read-mode settle cycles", setup_cnt, SETUP);
    chk(wn == w1 - w0, "R5", "words strobed", wn, w1 - w0);
    for (int i = 0; i < wn && i < 64; i++)
      if (wlog[i] != w0 + i && mism < 0) mism = i;
    chk(mism < 0, "R5", "word order", mism, -1);
    chk(bad_run == 0 && bad_ctrl == 0, "R3", "strobe width/ctrl errors", bad_run + bad_ctrl, 0);
    chk(bad_gap == 0, "R4", "hold before bytes errors", bad_gap, 0);
    chk(bn == cnt, "R6", "byte count", bn, cnt);
    mism = -1;
    for (int i = 0; i < bn && i < 256; i++)
      if (blog[i] != fb(off + i) && mism < 0) mism = i;
    chk(mism < 0, "R6", "byte content index", mism, -1);
    chk(bad_stab == 0 && bad_overlap == 0, "R7", "stall/overlap errors", bad_stab + bad_overlap, 0);
    chk(busy_ready == 0, "R11", "ready while busy", busy_ready, 0);
  endtask

  initial begin
    clear_log();
    #23;
    chk(ctrl == 32'h21, "R1", "ctrl in reset", ctrl, 32'h21);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl == 32'h21 && req_ready && !bvalid && !done, "R1", "idle outputs",
        {ctrl, req_ready, bvalid, done}, {32'h21, 3'b100});

    for (int v = 0; v < NV; v++) begin
      issue(int'(V_OFF[v]), int'(V_CNT[v]), V_STALL[v]);
      check_read(int'(V_OFF[v]), int'(V_CNT[v]));
    end

    // R9 zero-length
    issue(10, 0, 1'b0);
    chk(!done_err && wn == 0 && bn == 0, "R9", "zero length err/strobes/bytes",
        {done_err, 8'(wn), 8'(bn)}, 0);
    chk(ctrl_at_done == 32'h21, "R9", "standby kept", ctrl_at_done, 32'h21);

    // R10 past end of array
    issue(125, 4, 1'b0);
    chk(done_err && wn == 0 && bn == 0, "R10", "overrun refused",
        {done_err, 8'(wn), 8'(bn)}, {1'b1, 16'd0});
    issue(200, 5, 1'b1);
    chk(done_err && wn == 0 && bn == 0, "R10", "far offset refused",
        {done_err, 8'(wn), 8'(bn)}, {1'b1, 16'd0});

    // R1 back to idle after all traffic
    @(negedge clk);
    chk(ctrl == 32'h21 && req_ready, "R1", "idle after tests", {ctrl, req_ready}, {32'h21, 1'b1});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule